// File: doc/BRIEF.md
# Pipelined Binary-to-Residue Converter

This block takes an unsigned binary word and produces its remainder with respect to every modulus in a fixed, parameterized set of primes. It uses no divider. For each modulus, a lane repeatedly folds the operand. In each fold, every set bit `i` contributes the constant `2^i mod m`, and these contributions are summed in carry-save form and then resolved with one carry-propagate adder. Every fold narrows the operand. When the largest value the operand can still hold falls below `2m`, a last stage subtracts `m` if the operand is not already below it.

The fold count for each lane, and the width after each fold, are worked out at elaboration from the input width and the modulus. Lanes that need fewer folds are padded with plain registers, so all residues leave the block in the same cycle. A valid bit travels next to the data. The usual use is as the front end of a residue-arithmetic datapath. For inputs below the product of the moduli, the output tuple is a unique encoding of the input.

Top module: `rns_fwd_conv`

## Requirements
- R1: When `out_valid` is high, lane k of `out_residue`, at bits `[k*RES_W +: RES_W]` with lane 0 in the least significant bits, equals X mod m_k. Here X is the word captured with `in_valid`, and m_k is the modulus in bits `[k*16 +: 16]` of `MODULI`.
- R2: `out_valid` repeats `in_valid` exactly LAT clock cycles later. LAT is one more than the largest fold count among the lanes. With the defaults (12-bit input, moduli 5, 7, 11, 13), three folds are needed and LAT is 4.
- R3: A synchronous reset clears `out_valid` at the reset edge. No word that was presented during, or in the LAT cycles before, a reset cycle ever comes out as valid.
- R4: Whenever `out_valid` is high, every lane's residue is strictly below that lane's modulus.
- R5: A new word can be accepted on every clock. Back-to-back inputs produce back-to-back outputs, and idle input cycles reappear as idle output cycles in the same positions.
- R6: An all-zeros input gives 0 in every lane. The all-ones 12-bit input (4095) gives 0, 0, 3, 0 for moduli 5, 7, 11, 13.
- R7: Multiples of a modulus give residue 0, and a multiple minus one gives m−1. These inputs drive the final correction through both its subtract path and its pass path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_data` as a word to convert |
| in_data | input | IN_W | Unsigned binary operand |
| out_valid | output | 1 | Marks `out_residue` as holding residues |
| out_residue | output | NUM_MOD*RES_W | Packed residues, lane 0 in the low bits |

## Verification
The bench targets three kinds of corner case:

- **Correction boundaries.** Each modulus gets inputs at k·m and k·m−1. A comparison that is off by one, or that uses `>` instead of `>=`, would return m instead of 0, or would subtract from m−1 and wrap.
- **All-ones input.** This word maximizes the first fold sum. A lane with a fold width that is too narrow would drop a carry there and return a wrong residue.
- **Gaps and resets.** Valid patterns with gaps and a reset in mid-stream check the latency and the flush. A mismatch in the pipeline depth between lanes, or between data and valid, shows up as residues that belong to a neighbouring word. A flush that leaks would let a word that was killed by reset come out as valid.

// File: rtl/rns_pkg.sv
`timescale 1ns/1ps
package rns_pkg;

  // Each modulus occupies a fixed field of the packed modulus list.
  localparam int unsigned MOD_FIELD_W = 16;
  localparam int unsigned MAX_LANES   = 16;
  localparam int unsigned MOD_LIST_W  = MOD_FIELD_W * MAX_LANES;
  // Guard on the fold recursion; real chains stop far earlier.
  localparam int unsigned FOLD_CAP    = 32;

  // Which of the two final paths produced a residue.
  typedef enum logic {
    CORR_PASS = 1'b0,
    CORR_SUB  = 1'b1
  } corr_path_e;

  // Constant 2^idx mod modulus.
  function automatic int unsigned pow2_mod(int unsigned idx, int unsigned modulus);
    longint unsigned r;
    r = longint'(1) % longint'(modulus);
    for (int unsigned j = 0; j < idx; j++) begin
      r = (r * 2) % longint'(modulus);
    end
    return int'(r);
  endfunction

  // Bits needed to hold value (at least one).
  function automatic int unsigned bits_for(longint unsigned value);
    int unsigned n;
    n = 1;
    while (n < 63 && (longint'(1) << n) <= value) n++;
    return n;
  endfunction

  // Folded sum of the low n_bits of v: set bit i adds 2^i mod m.
  function automatic longint unsigned fold_value(longint unsigned v, int unsigned n_bits,
                                                 int unsigned modulus);
    longint unsigned acc;
    longint unsigned w;
    acc = 0;
    w   = longint'(1) % longint'(modulus);
    for (int unsigned j = 0; j < n_bits; j++) begin
      if (v[j]) acc += w;
      w = (w * 2) % longint'(modulus);
    end
    return acc;
  endfunction

  // Exact largest fold result over all operands 0..b.
  function automatic longint unsigned fold_bound(longint unsigned b, int unsigned modulus);
    int unsigned     nb;
    longint unsigned best;
    longint unsigned f;
    nb   = bits_for(b);
    best = 0;
    if (b == ((longint'(1) << nb) - 1)) return fold_value(b, nb, modulus);
    for (longint unsigned v = 0; v <= b; v++) begin
      f = fold_value(v, nb, modulus);
      if (f > best) best = f;
    end
    return best;
  endfunction

  // Operand bound after a given number of folds.
  function automatic longint unsigned bound_after(int unsigned in_w, int unsigned modulus,
                                                  int unsigned steps);
    longint unsigned b;
    b = (longint'(1) << in_w) - 1;
    for (int unsigned j = 0; j < steps; j++) b = fold_bound(b, modulus);
    return b;
  endfunction

  // Folds needed before one conditional subtraction suffices.
  function automatic int unsigned fold_count(int unsigned in_w, int unsigned modulus);
    longint unsigned b;
    int unsigned     n;
    b = (longint'(1) << in_w) - 1;
    n = 0;
    while (b >= 2 * longint'(modulus) && n < FOLD_CAP) begin
      b = fold_bound(b, modulus);
      n++;
    end
    return n;
  endfunction

  function automatic int unsigned lane_modulus(logic [MOD_LIST_W-1:0] list, int unsigned lane);
    return int'(list[lane*MOD_FIELD_W +: MOD_FIELD_W]);
  endfunction

  function automatic int unsigned max_modulus(logic [MOD_LIST_W-1:0] list, int unsigned n);
    int unsigned best;
    best = 2;
    for (int unsigned j = 0; j < n; j++) begin
      if (lane_modulus(list, j) > best) best = lane_modulus(list, j);
    end
    return best;
  endfunction

  function automatic int unsigned max_folds(int unsigned in_w, logic [MOD_LIST_W-1:0] list,
                                            int unsigned n);
    int unsigned best;
    best = 0;
    for (int unsigned j = 0; j < n; j++) begin
      if (fold_count(in_w, lane_modulus(list, j)) > best)
        best = fold_count(in_w, lane_modulus(list, j));
    end
    return best;
  endfunction

endpackage

// File: rtl/rns_pipe_reg.sv
`timescale 1ns/1ps
// Plain data delay used to align lanes with short fold chains.
module rns_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    q <= d;
  end

endmodule

// File: rtl/rns_fold_stage.sv
`timescale 1ns/1ps
// One registered fold: sum of per-bit weights 2^i mod M in carry-save form,
// resolved by a single adder of OUT_W bits.
module rns_fold_stage
  import rns_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned M     = 5,
  parameter int unsigned OUT_W = 5
) (
  input  logic          clk,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  logic [OUT_W-1:0] term [DW];
  logic [OUT_W-1:0] cs_sum;
  logic [OUT_W-1:0] cs_carry;
  logic [OUT_W-1:0] fold_sum;

  for (genvar i = 0; i < DW; i++) begin : g_term
    localparam int unsigned WGT = pow2_mod(i, M);
    assign term[i] = din[i] ? OUT_W'(WGT) : '0;
  end

  // Carry-save accumulation; exact modulo 2^OUT_W and the true sum fits.
  always_comb begin
    logic [OUT_W-1:0] s;
    logic [OUT_W-1:0] c;
    logic [OUT_W-1:0] ns;
    logic [OUT_W-1:0] nc;
    s = '0;
    c = '0;
    for (int i = 0; i < int'(DW); i++) begin
      ns = s ^ c ^ term[i];
      nc = ((s & c) | (s & term[i]) | (c & term[i])) << 1;
      s  = ns;
      c  = nc;
    end
    cs_sum   = s;
    cs_carry = c;
  end

  assign fold_sum = cs_sum + cs_carry;

  always_ff @(posedge clk) begin
    dout <= DW'(fold_sum);
  end

endmodule

// File: rtl/rns_correct.sv
`timescale 1ns/1ps
// Final stage: the operand is below 2M, so one subtract-or-pass gives the residue.
module rns_correct
  import rns_pkg::*;
#(
  parameter int unsigned DW = 12,
  parameter int unsigned M  = 5,
  parameter int unsigned RW = 4
) (
  input  logic          clk,
  input  logic [DW-1:0] val,
  output logic [RW-1:0] residue
);

  localparam int unsigned MW = bits_for(M);
  localparam int unsigned EW = ((DW > MW) ? DW : MW) + 1;

  logic [EW-1:0] ext;
  logic [EW-1:0] diff;
  logic [EW-1:0] pick;
  corr_path_e    path;

  assign ext  = EW'(val);
  assign diff = ext - EW'(M);
  assign path = (ext >= EW'(M)) ? CORR_SUB : CORR_PASS;
  assign pick = (path == CORR_SUB) ? diff : ext;

  always_ff @(posedge clk) begin
    residue <= RW'(pick);
  end

endmodule

// File: rtl/rns_lane.sv
`timescale 1ns/1ps
// Residue lane for one modulus: NF fold stages, padding to MAX_F, correction.
module rns_lane
  import rns_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned M     = 5,
  parameter int unsigned MAX_F = 3,
  parameter int unsigned RW    = 4
) (
  input  logic          clk,
  input  logic [DW-1:0] din,
  output logic [RW-1:0] residue
);

  localparam int unsigned NF = fold_count(DW, M);

  logic [MAX_F:0][DW-1:0] stage_q;

  assign stage_q[0] = din;

  for (genvar k = 0; k < int'(MAX_F); k++) begin : g_stage
    if (k < int'(NF)) begin : g_fold
      localparam int unsigned OW = bits_for(bound_after(DW, M, k + 1));
      rns_fold_stage #(
        .DW    (DW),
        .M     (M),
        .OUT_W (OW)
      ) u_fold (
        .clk  (clk),
        .din  (stage_q[k]),
        .dout (stage_q[k+1])
      );
    end else begin : g_pad
      rns_pipe_reg #(
        .W (DW)
      ) u_pad (
        .clk (clk),
        .d   (stage_q[k]),
        .q   (stage_q[k+1])
      );
    end
  end

  rns_correct #(
    .DW (DW),
    .M  (M),
    .RW (RW)
  ) u_corr (
    .clk     (clk),
    .val     (stage_q[MAX_F]),
    .residue (residue)
  );

endmodule

// File: rtl/rns_fwd_conv.sv
`timescale 1ns/1ps
// Binary to residue converter over a parameterized set of moduli.
module rns_fwd_conv
  import rns_pkg::*;
#(
  parameter int unsigned IN_W    = 12,
  parameter int unsigned NUM_MOD = 4,
  parameter logic [NUM_MOD*MOD_FIELD_W-1:0] MODULI = {16'd13, 16'd11, 16'd7, 16'd5},
  localparam int unsigned RES_W  = bits_for(max_modulus(MOD_LIST_W'(MODULI), NUM_MOD) - 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [IN_W-1:0]          in_data,
  output logic                     out_valid,
  output logic [NUM_MOD*RES_W-1:0] out_residue
);

  localparam int unsigned MAX_F = max_folds(IN_W, MOD_LIST_W'(MODULI), NUM_MOD);
  localparam int unsigned LAT   = MAX_F + 1;

  logic [LAT-1:0] valid_pipe;

  always_ff @(posedge clk) begin
    if (rst) valid_pipe <= '0;
    else     valid_pipe <= (valid_pipe << 1) | LAT'(in_valid);
  end

  assign out_valid = valid_pipe[LAT-1];

  for (genvar k = 0; k < int'(NUM_MOD); k++) begin : g_lane
    localparam int unsigned LANE_M = lane_modulus(MOD_LIST_W'(MODULI), k);
    rns_lane #(
      .DW    (IN_W),
      .M     (LANE_M),
      .MAX_F (MAX_F),
      .RW    (RES_W)
    ) u_lane (
      .clk     (clk),
      .din     (in_data),
      .residue (out_residue[k*RES_W +: RES_W])
    );
  end

endmodule

// File: rtl/rns_fwd_conv_chk.sv
`timescale 1ns/1ps
// Port-level checker: a shadow of input words delayed by LAT, with residues
// recomputed by the % operator.
module rns_fwd_conv_chk
  import rns_pkg::*;
#(
  parameter int unsigned IN_W    = 12,
  parameter int unsigned NUM_MOD = 4,
  parameter logic [NUM_MOD*MOD_FIELD_W-1:0] MODULI = {16'd13, 16'd11, 16'd7, 16'd5},
  localparam int unsigned RES_W  = bits_for(max_modulus(MOD_LIST_W'(MODULI), NUM_MOD) - 1)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [IN_W-1:0]          in_data,
  input logic                     out_valid,
  input logic [NUM_MOD*RES_W-1:0] out_residue
);

  localparam int unsigned LAT = max_folds(IN_W, MOD_LIST_W'(MODULI), NUM_MOD) + 1;

  logic [LAT-1:0]  sh_valid;
  logic [IN_W-1:0] sh_data [LAT];
  logic [IN_W-1:0] tail_data;

  always_ff @(posedge clk) begin
    if (rst) sh_valid <= '0;
    else     sh_valid <= (sh_valid << 1) | LAT'(in_valid);
  end

  always_ff @(posedge clk) begin
    sh_data[0] <= in_data;
    for (int j = 1; j < int'(LAT); j++) sh_data[j] <= sh_data[j-1];
  end

  assign tail_data = sh_data[LAT-1];

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == sh_valid[LAT-1]); // R2

  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid); // R3

  for (genvar k = 0; k < int'(NUM_MOD); k++) begin : g_lane_chk
    localparam int unsigned LANE_M = lane_modulus(MOD_LIST_W'(MODULI), k);

    AST_RESIDUE_EXACT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_residue[k*RES_W +: RES_W] ==
                    RES_W'(longint'(tail_data) % longint'(LANE_M))); // R1

    AST_RESIDUE_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> int'(out_residue[k*RES_W +: RES_W]) < int'(LANE_M)); // R4
  end

endmodule

bind rns_fwd_conv rns_fwd_conv_chk #(
  .IN_W    (IN_W),
  .NUM_MOD (NUM_MOD),
  .MODULI  (MODULI)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_residue (out_residue)
);

// File: tb/rns_fwd_conv_tb.sv
`timescale 1ns/1ps
module rns_fwd_conv_tb;

  localparam int IN_W    = 12;
  localparam int NUM_MOD = 4;
  localparam int RW      = 4;
  localparam int LAT     = 4;   // R2: three folds plus correction for the defaults
  localparam int MODS [NUM_MOD] = '{5, 7, 11, 13};

  typedef struct {
    logic            v;
    logic [IN_W-1:0] d;
    string           tag;
  } exp_t;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   in_valid = 1'b0;
  logic [IN_W-1:0]        in_data = '0;
  logic                   out_valid;
  logic [NUM_MOD*RW-1:0]  out_residue;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  exp_t q [$];

  always #2.5 clk = ~clk;

  rns_fwd_conv #(
    .IN_W    (IN_W),
    .NUM_MOD (NUM_MOD),
    .MODULI  ({16'd13, 16'd11, 16'd7, 16'd5})
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_residue (out_residue)
  );

  task automatic check_out(input exp_t e);
    int got;
    int want;
    checks++;
    if (out_valid !== e.v) begin
      errors++;
      $display("FAIL %s out_valid actual=%b expected=%b", {"R2/", e.tag}, out_valid, e.v);
    end
    if (e.v) begin
      for (int k = 0; k < NUM_MOD; k++) begin
        got  = int'(out_residue[k*RW +: RW]);
        want = int'(e.d) % MODS[k];
        checks++;
        if (got != want) begin
          errors++;
          $display("FAIL %s lane %0d x=%0d actual=%0d expected=%0d", e.tag, k, e.d, got, want);
        end
        checks++;
        if (got >= MODS[k]) begin
          errors++;
          $display("FAIL R4 lane %0d residue actual=%0d expected below %0d", k, got, MODS[k]);
        end
      end
    end
  endtask

  // One cycle: check outputs at the falling edge, then drive the next input.
  task automatic step(input logic v, input logic [IN_W-1:0] d, input string tag,
                      input logic r);
    exp_t e;
    @(negedge clk);
    if (q.size() >= LAT) e = q.pop_front();
    else begin
      e.v = 1'b0; e.d = '0; e.tag = "R3";
    end
    check_out(e);
    if (r) begin
      foreach (q[i]) begin
        q[i].v   = 1'b0;   // R3: words in flight are flushed
        q[i].tag = "R3";
      end
    end
    rst      = r;
    in_valid = r ? 1'b0 : v;
    in_data  = d;
    e.v   = r ? 1'b0 : v;
    e.d   = d;
    e.tag = r ? "R3" : tag;
    q.push_back(e);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R3: reset state, outputs idle
    for (int i = 0; i < 3; i++) step(1'b0, '0, "R3", 1'b1);
    for (int i = 0; i < LAT; i++) step(1'b0, '0, "R3", 1'b0);

    // R6: extreme words
    step(1'b1, 12'd0, "R6", 1'b0);
    step(1'b1, 12'hFFF, "R6", 1'b0);
    step(1'b0, '0, "R2", 1'b0);
    step(1'b1, 12'hFFF, "R6", 1'b0);
    step(1'b1, 12'd0, "R6", 1'b0);

    // R7: multiples and multiples minus one, with gaps between pairs
    for (int k = 0; k < NUM_MOD; k++) begin
      for (int j = 1; j * MODS[k] < 4096; j = j * 3 + 1) begin
        step(1'b1, 12'(j * MODS[k]), "R7", 1'b0);
        step(1'b1, 12'(j * MODS[k] - 1), "R7", 1'b0);
        step(1'b0, '0, "R2", 1'b0);
      end
      step(1'b1, 12'((4095 / MODS[k]) * MODS[k]), "R7", 1'b0);
      step(1'b1, 12'((4095 / MODS[k]) * MODS[k] - 1), "R7", 1'b0);
    end

    // R5: full-rate random words
    for (int i = 0; i < 300; i++) step(1'b1, 12'($urandom), "R5", 1'b0);

    // R2: random bubbles in the valid stream
    for (int i = 0; i < 200; i++) step(1'($urandom), 12'($urandom), "R1", 1'b0);

    // R3: reset in mid-stream kills words in flight
    for (int i = 0; i < 3; i++) step(1'b1, 12'($urandom), "R1", 1'b0);
    step(1'b1, 12'd77, "R3", 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 12'($urandom), "R1", 1'b0);

    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, "R2", 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule